// File: doc/BRIEF.md
# Serial Calendar Clock Emulator

This block models a serial-interface calendar clock chip that sits behind one 6-bit bus register. Host software writes the register to drive a data-in line, a shift clock, a strobe and a 3-bit command. It reads back the serial data-out bit and the interrupt status. Inside, a 40-bit time register runs from a fast system clock and advances once per second. A 40-bit shift register is the serial window into it. A strobe rising edge latches a command. The command can copy the time into the shift register, load the time from it, or pick a timer rate that drives an active-low interrupt as a square wave.

Timekeeping uses a power-on-only reset. The host reset clears only the bus register, so the time, the latched command and the shift register all survive a host reset. Both the shift clock and the strobe act on rising edges of register bits that software writes. Holding a bit high does nothing further.

Time layout, bit 0 first: seconds BCD [7:0], minutes BCD [15:8], hours BCD [23:16], day of month BCD [31:24], day of week [35:32] (0 is Sunday), month in binary 1 to 12 [39:36].

Top module: `sercal_clock`

## Requirements
- R1: After power-on reset the time is 40'h1001000000 (midnight, day 01, month 1, day of week 0) and irq_n is high.
- R2: The write fields are din = wr_data[0], sclk = wr_data[1], stb = wr_data[2] and cmd = wr_data[5:3]. The read fields are rd_data[0] = shift register bit 0 and rd_data[1] = 1 while irq_n is low.
- R3: A command is latched only on a rising edge of stb. Changing cmd while stb stays high has no effect.
- R4: With command 1 (shift) latched, each rising edge of sclk shifts the register right by one, with din entering bit 39. A falling edge does nothing.
- R5: With command 0 (hold) latched, sclk edges leave the shift register unchanged.
- R6: A strobe edge with cmd 3 (time read) copies the running time into the shift register.
- R7: A strobe edge with cmd 2 (time set) loads the shift register into the time and restarts the one-second prescaler, so the first advance comes CLK_HZ cycles later.
- R8: Every CLK_HZ cycles the time advances by one second in BCD. Seconds and minutes wrap after 59 and hours after 23.
- R9: The day of month wraps to 01 after the month's last day (28 for February, 30 for months 4, 6, 9 and 11, otherwise 31). The month wraps from 12 to 1, and the day of week counts 0 to 6.
- R10: Commands 4, 5, 6 and 7 make irq_n a square wave at 64, 256, 2048 and 4096 Hz (period CLK_HZ/rate cycles). Under commands 0 to 3, irq_n stays high.
- R11: Host reset clears the bus register but leaves the time, the latched command and the timer output running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| por_n | input | 1 | Active-low power-on reset for all state |
| host_rst_n | input | 1 | Active-low host reset, clears the bus register only |
| wr_en | input | 1 | Write strobe for the bus register |
| wr_data | input | 6 | Written value: din, sclk, stb, cmd |
| rd_data | output | 2 | Read value: data-out bit, interrupt status |
| irq_n | output | 1 | Active-low timer interrupt |

## Verification
A bus write lands in the register on the first clock edge. The edge detector acts on the second edge, so every bench write waits three clock cycles before it samples rd_data on a falling clock edge. The one-second advance comes exactly CLK_HZ cycles after a time set. The bench therefore reads the time snapshot either a few hundred cycles before that boundary or just after it, and never near it. The timer period is measured between two falling edges of irq_n, so the phase at which the rate was selected has no effect on the result.

// File: rtl/sercal_pkg.sv
package sercal_pkg;

    localparam int TIME_W = 40;

    typedef enum logic [2:0] {
        CMD_HOLD  = 3'd0,
        CMD_SHIFT = 3'd1,
        CMD_SET   = 3'd2,
        CMD_READ  = 3'd3,
        CMD_T64   = 3'd4,
        CMD_T256  = 3'd5,
        CMD_T2K   = 3'd6,
        CMD_T4K   = 3'd7
    } cmd_e;

    typedef struct packed {
        logic [3:0] month;
        logic [3:0] dow;
        logic [7:0] mday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    typedef struct packed {
        logic [2:0] cmd;
        logic       stb;
        logic       sclk;
        logic       din;
    } busreg_t;

    typedef struct packed {
        logic              prev_sclk;
        logic              prev_stb;
        cmd_e              cmd;
        logic [TIME_W-1:0] sreg;
    } core_t;

    localparam cal_t CAL_POWERUP = 40'h10_01_00_00_00;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] month_last(input logic [3:0] m);
        case (m)
            4'd2:                        return 8'h28;
            4'd4, 4'd6, 4'd9, 4'd11:     return 8'h30;
            default:                     return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/sercal_calendar.sv
module sercal_calendar
    import sercal_pkg::*;
#(
    parameter int CLK_HZ = 54_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic load,
    input  cal_t load_val,
    output cal_t time_o
);

    localparam int PW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
    localparam logic [PW-1:0] PRE_MAX = PW'(CLK_HZ - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        cal_t          cal;
    } cal_state_t;

    cal_state_t st_d, st_q;
    logic       tick;

    assign tick = (st_q.pre == PRE_MAX);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.pre = '0;
            st_d.cal = load_val;
        end else if (tick) begin
            st_d.pre = '0;
            if (st_q.cal.sec != 8'h59) begin
                st_d.cal.sec = bcd_inc(st_q.cal.sec);
            end else begin
                st_d.cal.sec = 8'h00;
                if (st_q.cal.min != 8'h59) begin
                    st_d.cal.min = bcd_inc(st_q.cal.min);
                end else begin
                    st_d.cal.min = 8'h00;
                    if (st_q.cal.hour != 8'h23) begin
                        st_d.cal.hour = bcd_inc(st_q.cal.hour);
                    end else begin
                        st_d.cal.hour = 8'h00;
                        st_d.cal.dow  = (st_q.cal.dow == 4'd6) ? 4'd0 : st_q.cal.dow + 4'd1;
                        if (st_q.cal.mday == month_last(st_q.cal.month)) begin
                            st_d.cal.mday  = 8'h01;
                            st_d.cal.month = (st_q.cal.month == 4'd12) ? 4'd1 : st_q.cal.month + 4'd1;
                        end else begin
                            st_d.cal.mday = bcd_inc(st_q.cal.mday);
                        end
                    end
                end
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.pre <= '0;
            st_q.cal <= CAL_POWERUP;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_o = st_q.cal;

    // R8: seconds wrap from 59 to 00 on a tick
    p_sec_wrap_r8: assert property (@(posedge clk) disable iff (!por_n)
        (tick && !load && st_q.cal.sec == 8'h59) |=> (st_q.cal.sec == 8'h00));

    // R9: the last second of December wraps to the first of January
    p_year_wrap_r9: assert property (@(posedge clk) disable iff (!por_n)
        (tick && !load && st_q.cal.month == 4'd12 && st_q.cal.mday == 8'h31 &&
         st_q.cal.hour == 8'h23 && st_q.cal.min == 8'h59 && st_q.cal.sec == 8'h59)
        |=> (st_q.cal.month == 4'd1 && st_q.cal.mday == 8'h01));

    // R7: a load restarts the prescaler
    p_load_restart_r7: assert property (@(posedge clk) disable iff (!por_n)
        load |=> (st_q.pre == '0 && st_q.cal == $past(load_val)));

endmodule

// File: rtl/sercal_pulse.sv
module sercal_pulse #(
    parameter int CLK_HZ = 54_000_000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       en,
    input  logic [1:0] rate,
    input  logic       restart,
    output logic       irq_n
);

    localparam int HW = $clog2(CLK_HZ / 128 + 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          lvl;
    } pulse_t;

    pulse_t st_d, st_q;

    function automatic int half_of(input logic [1:0] r);
        case (r)
            2'd0:    return CLK_HZ / 128;
            2'd1:    return CLK_HZ / 512;
            2'd2:    return CLK_HZ / 4096;
            default: return CLK_HZ / 8192;
        endcase
    endfunction

    logic [HW-1:0] last;
    assign last = HW'(half_of(rate) - 1);

    always_comb begin
        st_d = st_q;
        if (!en || restart) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b1;
        end else if (st_q.cnt == last) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.cnt <= '0;
            st_q.lvl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = st_q.lvl;

    // R10: the output only toggles when the counter reaches its limit
    p_toggle_at_limit_r10: assert property (@(posedge clk) disable iff (!por_n)
        (en && !restart && st_q.cnt != last) |=> $stable(irq_n));

endmodule

// File: rtl/sercal_clock.sv
module sercal_clock
    import sercal_pkg::*;
#(
    parameter int CLK_HZ = 54_000_000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       host_rst_n,
    input  logic       wr_en,
    input  logic [5:0] wr_data,
    output logic [1:0] rd_data,
    output logic       irq_n
);

    busreg_t bus_d, bus_q;
    core_t   core_d, core_q;
    cal_t    cal_now;
    logic    sclk_rise, stb_rise, cal_load;
    logic [2:0] cmd_bits;

    assign sclk_rise = bus_q.sclk & ~core_q.prev_sclk;
    assign stb_rise  = bus_q.stb  & ~core_q.prev_stb;
    assign cal_load  = stb_rise && (bus_q.cmd == CMD_SET);
    assign cmd_bits  = core_q.cmd;

    always_comb begin
        bus_d = bus_q;
        if (wr_en) bus_d = busreg_t'(wr_data);

        core_d           = core_q;
        core_d.prev_sclk = bus_q.sclk;
        core_d.prev_stb  = bus_q.stb;
        if (stb_rise) begin
            core_d.cmd = cmd_e'(bus_q.cmd);
            if (bus_q.cmd == CMD_READ) core_d.sreg = cal_now;
        end else if (sclk_rise && core_q.cmd == CMD_SHIFT) begin
            core_d.sreg = {bus_q.din, core_q.sreg[TIME_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n || !host_rst_n) bus_q <= '0;
        else                       bus_q <= bus_d;
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            core_q.prev_sclk <= 1'b0;
            core_q.prev_stb  <= 1'b0;
            core_q.cmd       <= CMD_HOLD;
            core_q.sreg      <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    sercal_calendar #(.CLK_HZ(CLK_HZ)) u_calendar (
        .clk      (clk),
        .por_n    (por_n),
        .load     (cal_load),
        .load_val (cal_t'(core_q.sreg)),
        .time_o   (cal_now)
    );

    sercal_pulse #(.CLK_HZ(CLK_HZ)) u_pulse (
        .clk     (clk),
        .por_n   (por_n),
        .en      (cmd_bits[2]),
        .rate    (cmd_bits[1:0]),
        .restart (stb_rise),
        .irq_n   (irq_n)
    );

    assign rd_data = {~irq_n, core_q.sreg[0]};

    // R10: non-timer commands keep the interrupt released
    p_irq_idle_r10: assert property (@(posedge clk) disable iff (!por_n)
        (!cmd_bits[2]) |=> irq_n);

    // R5: hold mode freezes the shift register
    p_hold_freeze_r5: assert property (@(posedge clk) disable iff (!por_n)
        (core_q.cmd == CMD_HOLD && !stb_rise) |=> $stable(core_q.sreg));

    // R4: one shift-clock edge moves the register by one place
    p_shift_step_r4: assert property (@(posedge clk) disable iff (!por_n)
        (core_q.cmd == CMD_SHIFT && sclk_rise && !stb_rise)
        |=> (core_q.sreg[TIME_W-2:0] == $past(core_q.sreg[TIME_W-1:1])));

    // R11: host reset cannot trigger a time load
    p_hostrst_noload_r11: assert property (@(posedge clk) disable iff (!por_n)
        (!host_rst_n) |=> !cal_load);

endmodule

// File: tb/sercal_clock_bench.sv
module sercal_clock_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HZ         = 16384;

    logic       clk = 1'b0;
    logic       por_n, host_rst_n, wr_en;
    logic [5:0] wr_data;
    logic [1:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sercal_clock #(.CLK_HZ(HZ)) u_sercal_clock (
        .clk        (clk),
        .por_n      (por_n),
        .host_rst_n (host_rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .irq_n      (irq_n)
    );

    task automatic check(input bit ok, input string tag, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // R2: field positions din[0] sclk[1] stb[2] cmd[5:3]
    task automatic bus_write(input logic din, input logic sclk, input logic stb, input logic [2:0] cmd);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {cmd, stb, sclk, din};
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic latch_cmd(input logic [2:0] cmd);
        bus_write(1'b0, 1'b0, 1'b0, cmd);
        bus_write(1'b0, 1'b0, 1'b1, cmd);
        bus_write(1'b0, 1'b0, 1'b0, cmd);
    endtask

    task automatic shift_out(output logic [39:0] v);
        latch_cmd(3'd1);
        for (int i = 0; i < 40; i++) begin
            v[i] = rd_data[0];
            bus_write(1'b0, 1'b1, 1'b0, 3'd1);
            bus_write(1'b0, 1'b0, 1'b0, 3'd1);
        end
    endtask

    task automatic read_time(output logic [39:0] v);
        latch_cmd(3'd3);
        shift_out(v);
    endtask

    task automatic load_time(input logic [39:0] v);
        latch_cmd(3'd1);
        for (int i = 0; i < 40; i++) begin
            bus_write(v[i], 1'b1, 1'b0, 3'd1);
            bus_write(v[i], 1'b0, 1'b0, 3'd1);
        end
        latch_cmd(3'd2);
    endtask

    task automatic measure_period(output int p);
        logic prv;
        int   t0;
        bit   seen;
        prv  = irq_n;
        p    = -1;
        seen = 0;
        t0   = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (prv && !irq_n) begin
                if (seen) begin
                    p = i - t0;
                    break;
                end
                seen = 1;
                t0   = i;
            end
            prv = irq_n;
        end
    endtask

    task automatic t_reset_state();
        logic [39:0] v;
        check(irq_n === 1'b1, "R1 irq_n after power-on", {39'd0, irq_n}, 40'd1);
        read_time(v);
        check(v === 40'h1001000000, "R1/R6 power-on time", v, 40'h1001000000);
    endtask

    task automatic t_second_step();
        logic [39:0] v;
        load_time(40'h6315095959);
        repeat (HZ - 300) @(negedge clk);
        read_time(v);
        check(v === 40'h6315095959, "R7 no advance before CLK_HZ cycles", v, 40'h6315095959);
        repeat (400) @(negedge clk);
        read_time(v);
        check(v === 40'h6315100000, "R8 minute and hour BCD carry", v, 40'h6315100000);
    endtask

    task automatic t_rollover(input logic [39:0] start, input logic [39:0] exp, input string tag);
        logic [39:0] v;
        load_time(start);
        repeat (HZ + 100) @(negedge clk);
        read_time(v);
        check(v === exp, tag, v, exp);
    endtask

    task automatic t_hold();
        logic [39:0] v;
        load_time(40'h2514073344);
        latch_cmd(3'd3);
        latch_cmd(3'd0);
        for (int i = 0; i < 5; i++) begin
            bus_write(1'b1, 1'b1, 1'b0, 3'd0);
            bus_write(1'b1, 1'b0, 1'b0, 3'd0);
        end
        shift_out(v);
        check(v === 40'h2514073344, "R5 sclk ignored in hold", v, 40'h2514073344);
    endtask

    task automatic t_timer();
        int p;
        int exp [4] = '{256, 64, 8, 4};
        for (int k = 0; k < 4; k++) begin
            latch_cmd(3'(4 + k));
            measure_period(p);
            check(p == exp[k], $sformatf("R10 period for cmd %0d", 4 + k), 40'(p), 40'(exp[k]));
        end
        while (irq_n !== 1'b0) @(negedge clk);
        check(rd_data[1] === 1'b1, "R2/R10 status while irq low", {39'd0, rd_data[1]}, 40'd1);
        while (irq_n !== 1'b1) @(negedge clk);
        check(rd_data[1] === 1'b0, "R2/R10 status while irq high", {39'd0, rd_data[1]}, 40'd0);
        latch_cmd(3'd0);
        begin
            bit stayed = 1;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (irq_n !== 1'b1) stayed = 0;
            end
            check(stayed, "R10 irq high in hold", {39'd0, stayed}, 40'd1);
        end
    endtask

    task automatic t_level_ignored();
        int p;
        bus_write(1'b0, 1'b0, 1'b0, 3'd7);
        bus_write(1'b0, 1'b0, 1'b1, 3'd7);
        bus_write(1'b0, 1'b0, 1'b1, 3'd4);
        measure_period(p);
        check(p == 4, "R3 held strobe does not relatch", 40'(p), 40'd4);
        bus_write(1'b0, 1'b0, 1'b0, 3'd4);
        bus_write(1'b0, 1'b0, 1'b1, 3'd4);
        measure_period(p);
        check(p == 256, "R3 new strobe edge latches", 40'(p), 40'd256);
    endtask

    task automatic t_host_reset();
        logic [39:0] v;
        int p;
        load_time(40'h7422182201);
        latch_cmd(3'd7);
        @(negedge clk);
        host_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        host_rst_n = 1'b1;
        measure_period(p);
        check(p == 4, "R11 timer survives host reset", 40'(p), 40'd4);
        read_time(v);
        check(v === 40'h7422182201, "R11 time survives host reset", v, 40'h7422182201);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        por_n      = 1'b0;
        host_rst_n = 1'b0;
        wr_en      = 1'b0;
        wr_data    = '0;
        repeat (4) @(negedge clk);
        por_n      = 1'b1;
        host_rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_second_step();
        t_rollover(40'h2628235959, 40'h3001000000, "R9 February 28 to March 1");
        t_rollover(40'h4230235959, 40'h5301000000, "R9 April 30 to May 1");
        t_rollover(40'hC631235959, 40'h1001000000, "R9 December to January");
        t_hold();
        t_timer();
        t_level_ignored();
        t_host_reset();
        finish_run();
    end

endmodule